// File: doc/BRIEF.md
# Framebuffer Scan-Out Controller

This block drives a fixed 640x480 true-colour panel from a linear image held in memory. A raster timing generator walks every clock of the line and frame. For each visible position it forms the byte address of one 32-bit pixel word and issues a single read on a simple memory port. The memory answers one cycle later, and the block splits the returned word into 8-bit red, green and blue outputs. Outside the visible area, and whenever the display is switched off, the colour outputs are held at zero and the port stays idle. The sync pulses keep running in both cases.

Software sees two 32-bit registers: the image base address and a control word. The control word has an enable bit and a bit that turns the picture upside down, which reverses the order in which addresses are visited. Only the top eleven bits of the base are kept, so an image always starts on a 2 MiB boundary. Each image row takes 1024 words of memory, of which the first 640 are shown. New register values reach the scan logic only on the first clock of vertical blanking, so a frame never shows a mix of old and new settings.

Top module: `fbs_scanout`

## Requirements
- R1: The line period is 800 clocks and the frame is 525 lines. The horizontal sync output is low for 96 clocks, starting 656 clocks into the line. The vertical sync output is low for 2 lines, starting at line 490. Both syncs run whether the display is enabled or not.
- R2: With rotation off, visible pixel (x, y) is read from byte address base + 4*(1024*y + x). Word columns 640 to 1023 of a row are never requested.
- R3: With rotation on, visible pixel (x, y) is read from byte address base + 4*(1024*(479 - y) + (639 - x)).
- R4: The block makes one read request, on the cycle after the raster counter reaches each visible pixel, when the display is enabled. It makes no request during horizontal or vertical blanking, and none at all while the display is disabled.
- R5: The memory returns the word in the cycle after the request. Bits 23:16 of that word drive red, bits 15:8 drive green and bits 7:0 drive blue. Bits 31:24 have no effect. The colours and both syncs appear three clocks after the raster position they belong to.
- R6: Red, green and blue are zero on every clock that carries no fetched pixel.
- R7: When reg_sel is 0 a write goes to the base register, which keeps bits 31:21 and reads the other bits back as zero. When reg_sel is 1 a write goes to the control register: bit 0 enables the display, bit 1 selects rotation, and the other bits read back as zero. Reads return the last written value at once.
- R8: Written values take effect only on the first clock of line 480. A write made on that same clock waits for the next frame. Clearing the control register therefore blanks the display from the next frame on, and writing the saved value back restores it.
- R9: After reset the display is disabled, both registers read zero, both syncs are high, the colours are zero and no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select (byte address bit 2): 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Pixel word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Pixel word, valid one cycle after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
The hardest case to reach from the ports is a control write that lands in the middle of a visible line. The write must be held back until vertical blanking, even though the shadow register already reads the new value. The bench waits for the first request of a run of visible pixels and clears the control word on that same clock. A few clocks later it checks that requests are still being issued, and it confirms that the display goes dark only from the next frame. The bench shrinks the timing parameters so that many frames fit in the run. Its memory model returns data that encodes the requested address, with a fixed upper byte, so any address, rotation or unpacking fault shows up directly in the colours.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    // Control word as seen by the scan logic; bit 0 is enable, bit 1 rotation.
    typedef struct packed {
        logic rot;
        logic en;
    } fbs_ctl_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } fbs_rgb_t;
endpackage

// File: rtl/fbs_timing.sv
module fbs_timing #(
    parameter int H_ACT = 640,
    parameter int H_FP  = 16,
    parameter int H_SYN = 96,
    parameter int H_BP  = 48,
    parameter int V_ACT = 480,
    parameter int V_FP  = 10,
    parameter int V_SYN = 2,
    parameter int V_BP  = 33,
    parameter int HW    = 10,
    parameter int VW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] pos_x,
    output logic [VW-1:0] pos_y,
    output logic          in_view,
    output logic          hs_n,
    output logic          vs_n,
    output logic          vblank_start
);
    localparam int H_TOT = H_ACT + H_FP + H_SYN + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYN + V_BP;
    localparam int HS_BEG = H_ACT + H_FP;
    localparam int HS_END = HS_BEG + H_SYN;
    localparam int VS_BEG = V_ACT + V_FP;
    localparam int VS_END = VS_BEG + V_SYN;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.h == HW'(H_TOT - 1)) begin
            pos_d.h = '0;
            if (pos_q.v == VW'(V_TOT - 1)) begin
                pos_d.v = '0;
            end else begin
                pos_d.v = pos_q.v + 1'b1;
            end
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_x        = pos_q.h;
    assign pos_y        = pos_q.v;
    assign in_view      = (pos_q.h < HW'(H_ACT)) && (pos_q.v < VW'(V_ACT));
    assign hs_n         = !((pos_q.h >= HW'(HS_BEG)) && (pos_q.h < HW'(HS_END)));
    assign vs_n         = !((pos_q.v >= VW'(VS_BEG)) && (pos_q.v < VW'(VS_END)));
    assign vblank_start = (pos_q.h == '0) && (pos_q.v == VW'(V_ACT));

    // R1: vertical sync may only move at the start of a line
    a_r1_vsync_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vs_n) |-> (pos_q.h == '0));
endmodule

// File: rtl/fbs_regs.sv
module fbs_regs
    import fbs_pkg::*;
#(
    parameter int BASE_KEEP = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 sel_ctl,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic                 vblank_start,
    output logic [BASE_KEEP-1:0] live_base,
    output fbs_ctl_t             live_ctl
);
    localparam int LOW_W = 32 - BASE_KEEP;

    typedef struct packed {
        logic [BASE_KEEP-1:0] sh_base;
        fbs_ctl_t             sh_ctl;
        logic [BASE_KEEP-1:0] lv_base;
        fbs_ctl_t             lv_ctl;
    } regs_t;

    regs_t regs_d, regs_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata[LOW_W-1:2];

    always_comb begin
        regs_d = regs_q;
        // The scan side takes the values held before any write of this cycle.
        if (vblank_start) begin
            regs_d.lv_base = regs_q.sh_base;
            regs_d.lv_ctl  = regs_q.sh_ctl;
        end
        if (wr) begin
            if (sel_ctl) begin
                regs_d.sh_ctl = fbs_ctl_t'(wdata[1:0]);
            end else begin
                regs_d.sh_base = wdata[31 -: BASE_KEEP];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata     = sel_ctl ? {30'd0, regs_q.sh_ctl} : {regs_q.sh_base, {LOW_W{1'b0}}};
    assign live_base = regs_q.lv_base;
    assign live_ctl  = regs_q.lv_ctl;
endmodule

// File: rtl/fbs_addr.sv
module fbs_addr
    import fbs_pkg::*;
#(
    parameter int H_ACT       = 640,
    parameter int V_ACT       = 480,
    parameter int HW          = 10,
    parameter int VW          = 10,
    parameter int STRIDE_LOG2 = 10,
    parameter int BASE_KEEP   = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HW-1:0]        pos_x,
    input  logic [VW-1:0]        pos_y,
    input  logic                 in_view,
    input  logic                 hs_n_in,
    input  logic                 vs_n_in,
    input  fbs_ctl_t             ctl,
    input  logic [BASE_KEEP-1:0] base,
    output logic                 req,
    output logic [31:0]          addr,
    output logic                 hs_n_out,
    output logic                 vs_n_out
);
    localparam int OFS_W = 32 - BASE_KEEP;
    localparam int ROW_W = OFS_W - STRIDE_LOG2 - 2;

    typedef struct packed {
        logic        req;
        logic [31:0] addr;
        logic        hs_n;
        logic        vs_n;
    } fetch_t;

    fetch_t f_d, f_q;
    logic [31:0] col_w, row_w;

    always_comb begin
        // Rotation mirrors both indices so the scan visits words in reverse.
        col_w = ctl.rot ? (32'(H_ACT - 1) - 32'(pos_x)) : 32'(pos_x);
        row_w = ctl.rot ? (32'(V_ACT - 1) - 32'(pos_y)) : 32'(pos_y);
        f_d      = f_q;
        f_d.req  = in_view && ctl.en;
        f_d.addr = {base, ROW_W'(row_w), STRIDE_LOG2'(col_w), 2'b00};
        f_d.hs_n = hs_n_in;
        f_d.vs_n = vs_n_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q      <= '0;
            f_q.hs_n <= 1'b1;
            f_q.vs_n <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign req      = f_q.req;
    assign addr     = f_q.addr;
    assign hs_n_out = f_q.hs_n;
    assign vs_n_out = f_q.vs_n;

    // R2: padding columns of a row are never fetched
    a_r2_col_in_view: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.req |-> (f_q.addr[STRIDE_LOG2+1:2] < STRIDE_LOG2'(H_ACT)));
endmodule

// File: rtl/fbs_unpack.sv
module fbs_unpack
    import fbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [31:0] rdata,
    input  logic        hs_n_in,
    input  logic        vs_n_in,
    output fbs_rgb_t    pix,
    output logic        hs_n_out,
    output logic        vs_n_out
);
    typedef struct packed {
        logic     pend;
        logic     hs_n2;
        logic     vs_n2;
        fbs_rgb_t pix;
        logic     hs_n3;
        logic     vs_n3;
    } up_t;

    up_t u_d, u_q;

    logic unused_top;
    assign unused_top = ^rdata[31:24];

    always_comb begin
        u_d       = u_q;
        u_d.pend  = req;
        u_d.hs_n2 = hs_n_in;
        u_d.vs_n2 = vs_n_in;
        u_d.hs_n3 = u_q.hs_n2;
        u_d.vs_n3 = u_q.vs_n2;
        if (u_q.pend) begin
            u_d.pix.r = rdata[23:16];
            u_d.pix.g = rdata[15:8];
            u_d.pix.b = rdata[7:0];
        end else begin
            u_d.pix = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q       <= '0;
            u_q.hs_n2 <= 1'b1;
            u_q.vs_n2 <= 1'b1;
            u_q.hs_n3 <= 1'b1;
            u_q.vs_n3 <= 1'b1;
        end else begin
            u_q <= u_d;
        end
    end

    assign pix      = u_q.pix;
    assign hs_n_out = u_q.hs_n3;
    assign vs_n_out = u_q.vs_n3;
endmodule

// File: rtl/fbs_scanout.sv
module fbs_scanout
    import fbs_pkg::*;
#(
    parameter int H_ACT       = 640,
    parameter int H_FP        = 16,
    parameter int H_SYN       = 96,
    parameter int H_BP        = 48,
    parameter int V_ACT       = 480,
    parameter int V_FP        = 10,
    parameter int V_SYN       = 2,
    parameter int V_BP        = 33,
    parameter int STRIDE_LOG2 = 10,
    parameter int BASE_KEEP   = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    output logic        hsync_n,
    output logic        vsync_n,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue
);
    localparam int H_TOT = H_ACT + H_FP + H_SYN + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYN + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);

    logic [HW-1:0]        t_x;
    logic [VW-1:0]        t_y;
    logic                 t_view, t_hs_n, t_vs_n, t_vbs;
    logic [BASE_KEEP-1:0] lv_base;
    fbs_ctl_t             lv_ctl;
    logic                 a_hs_n, a_vs_n;
    fbs_rgb_t             pix;

    fbs_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYN(H_SYN), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYN(V_SYN), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n),
        .pos_x(t_x), .pos_y(t_y), .in_view(t_view),
        .hs_n(t_hs_n), .vs_n(t_vs_n), .vblank_start(t_vbs)
    );

    fbs_regs #(.BASE_KEEP(BASE_KEEP)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .sel_ctl(reg_sel), .wdata(reg_wdata), .rdata(reg_rdata),
        .vblank_start(t_vbs), .live_base(lv_base), .live_ctl(lv_ctl)
    );

    fbs_addr #(
        .H_ACT(H_ACT), .V_ACT(V_ACT), .HW(HW), .VW(VW),
        .STRIDE_LOG2(STRIDE_LOG2), .BASE_KEEP(BASE_KEEP)
    ) u_addr (
        .clk(clk), .rst_n(rst_n),
        .pos_x(t_x), .pos_y(t_y), .in_view(t_view),
        .hs_n_in(t_hs_n), .vs_n_in(t_vs_n),
        .ctl(lv_ctl), .base(lv_base),
        .req(mem_req), .addr(mem_addr),
        .hs_n_out(a_hs_n), .vs_n_out(a_vs_n)
    );

    fbs_unpack u_unpack (
        .clk(clk), .rst_n(rst_n),
        .req(mem_req), .rdata(mem_rdata),
        .hs_n_in(a_hs_n), .vs_n_in(a_vs_n),
        .pix(pix), .hs_n_out(hsync_n), .vs_n_out(vsync_n)
    );

    assign red   = pix.r;
    assign green = pix.g;
    assign blue  = pix.b;

    // R4: a request always follows a visible raster position
    a_r4_req_needs_view: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(t_view));

    // R6: any colour must trace back to a request two clocks earlier
    a_r6_colour_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (|{red, green, blue}) |-> $past(mem_req, 2));

    // R8: the scan-side control word changes only after vertical blanking starts
    a_r8_ctl_at_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lv_ctl) |-> $past(t_vbs));
endmodule

// File: tb/tb_fbs_scanout.sv
`timescale 1ns/1ps
module tb_fbs_scanout;
    localparam int HA = 8, HF = 2, HS = 3, HB = 2;
    localparam int VA = 6, VF = 1, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int FR = HT * VT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, mem_addr;
    logic [31:0] mem_rdata = '0;
    logic mem_req, hsync_n, vsync_n;
    logic [7:0] red, green, blue;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fbs_scanout #(
        .H_ACT(HA), .H_FP(HF), .H_SYN(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SYN(VS), .V_BP(VB)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .red(red), .green(green), .blue(blue)
    );

    // Memory: fixed one-cycle latency, word encodes its own address, top byte junk.
    always @(posedge clk) mem_rdata <= {8'hC3, mem_addr[25:2]};

    // Reference model of the requirements.
    int mh = 0, mv = 0;
    logic [10:0] sh_base = '0, lv_base = '0;
    logic [1:0]  sh_ctl = '0, lv_ctl = '0;
    logic        e1_req = 1'b0, e1_rot = 1'b0;
    logic [31:0] e1_addr = '0;
    logic [25:0] px1 = {2'b11, 24'd0}, px2 = {2'b11, 24'd0}, px3 = {2'b11, 24'd0};

    always @(posedge clk) begin : model
        logic        rq, hs, vs;
        logic [31:0] a;
        int          row, col;
        if (!rst_n) begin
            mh = 0; mv = 0;
            sh_base <= '0; lv_base <= '0; sh_ctl <= '0; lv_ctl <= '0;
            e1_req <= 1'b0; e1_rot <= 1'b0; e1_addr <= '0;
            px1 <= {2'b11, 24'd0}; px2 <= {2'b11, 24'd0}; px3 <= {2'b11, 24'd0};
        end else begin
            rq  = lv_ctl[0] && (mh < HA) && (mv < VA);
            row = lv_ctl[1] ? (VA - 1 - mv) : mv;
            col = lv_ctl[1] ? (HA - 1 - mh) : mh;
            a   = {lv_base, 21'd0} + 32'((row * 1024 + col) * 4);
            hs  = !((mh >= HA + HF) && (mh < HA + HF + HS));
            vs  = !((mv >= VA + VF) && (mv < VA + VF + VS));
            e1_req  <= rq;
            e1_addr <= a;
            e1_rot  <= lv_ctl[1];
            px1 <= {hs, vs, (rq ? a[25:2] : 24'd0)};
            px2 <= px1;
            px3 <= px2;
            if (mh == 0 && mv == VA) begin
                lv_base <= sh_base;
                lv_ctl  <= sh_ctl;
            end
            if (reg_wr) begin
                if (reg_sel) sh_ctl <= reg_wdata[1:0];
                else         sh_base <= reg_wdata[31:21];
            end
            if (mh == HT - 1) begin
                mh = 0;
                mv = (mv == VT - 1) ? 0 : mv + 1;
            end else begin
                mh = mh + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model for n cycles, counting events.
    task automatic run(input int n, output int n_req, output int n_hlow, output int n_vlow);
        n_req = 0; n_hlow = 0; n_vlow = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(mem_req == e1_req, "R4", 32'(mem_req), 32'(e1_req));
            if (e1_req) chk(mem_addr == e1_addr, e1_rot ? "R3" : "R2", mem_addr, e1_addr);
            chk({hsync_n, vsync_n} == px3[25:24], "R1", 32'({hsync_n, vsync_n}), 32'(px3[25:24]));
            chk({red, green, blue} == px3[23:0], (px3[23:0] != 0) ? "R5" : "R6",
                32'({red, green, blue}), 32'(px3[23:0]));
            if (mem_req) n_req++;
            if (!hsync_n) n_hlow++;
            if (!vsync_n) n_vlow++;
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic sel, input logic [31:0] exp, input string req);
        reg_sel = sel;
        #0.5;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic first_req_of_frame(output logic [31:0] a);
        int guard = 0;
        while (vsync_n && guard < 4 * FR) begin @(negedge clk); guard++; end
        while (!mem_req && guard < 4 * FR) begin @(negedge clk); guard++; end
        a = mem_addr;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({hsync_n, vsync_n} == 2'b11, "R9", 32'({hsync_n, vsync_n}), 32'd3);
        chk({red, green, blue} == 24'd0, "R9", 32'({red, green, blue}), 32'd0);
        chk(mem_req == 1'b0, "R9", 32'(mem_req), 32'd0);
        rd_check(1'b0, 32'd0, "R9");
        rd_check(1'b1, 32'd0, "R9");
        rst_n = 1'b1;
    endtask

    task automatic t_disabled();
        int nr, nh, nv;
        run(FR, nr, nh, nv);
        run(FR, nr, nh, nv);
        chk(nr == 0, "R4", 32'(nr), 32'd0);
        chk(nh == HS * VT, "R1", 32'(nh), 32'(HS * VT));
        chk(nv == VS * HT, "R1", 32'(nv), 32'(VS * HT));
    endtask

    task automatic t_registers();
        wr(1'b0, 32'hFFFF_FFFF);
        rd_check(1'b0, 32'hFFE0_0000, "R7");
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check(1'b1, 32'h0000_0003, "R7");
        wr(1'b1, 32'h0);
        rd_check(1'b1, 32'h0, "R7");
        wr(1'b0, 32'h2A40_0000);
        rd_check(1'b0, 32'h2A40_0000, "R7");
    endtask

    task automatic t_normal();
        int nr, nh, nv;
        logic [31:0] a;
        wr(1'b1, 32'h1);
        run(2 * FR, nr, nh, nv);
        run(FR, nr, nh, nv);
        chk(nr == HA * VA, "R4", 32'(nr), 32'(HA * VA));
        first_req_of_frame(a);
        chk(a == 32'h2A40_0000, "R2", a, 32'h2A40_0000);
        run(FR, nr, nh, nv);
    endtask

    task automatic t_rotated();
        int nr, nh, nv;
        logic [31:0] a;
        wr(1'b1, 32'h3);
        run(2 * FR, nr, nh, nv);
        first_req_of_frame(a);
        chk(a == 32'h2A40_501C, "R3", a, 32'h2A40_501C);
        run(FR, nr, nh, nv);
        chk(nr == HA * VA, "R3", 32'(nr), 32'(HA * VA));
    endtask

    task automatic t_deferred();
        int nr, nh, nv;
        logic prev = 1'b1;
        int guard = 0;
        // Find the first request of a visible run, then clear control on that clock.
        while (!(mem_req && !prev) && guard < 4 * FR) begin
            prev = mem_req;
            @(negedge clk);
            guard++;
        end
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_req == 1'b1, "R8", 32'(mem_req), 32'd1);
        run(2 * FR, nr, nh, nv);
        run(FR, nr, nh, nv);
        chk(nr == 0, "R8", 32'(nr), 32'd0);
        wr(1'b1, 32'h3);
        run(2 * FR, nr, nh, nv);
        run(FR, nr, nh, nv);
        chk(nr == HA * VA, "R8", 32'(nr), 32'(HA * VA));
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_registers();
        t_normal();
        t_rotated();
        t_deferred();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule